// File: doc/BRIEF.md
# Frame-Synchronized Display Control Register Block

This block holds the frame-control settings of a display controller that runs in two clock domains. Software writes and reads the settings through a small register port clocked by the bus clock. The display logic runs on its own slower clock and uses an active copy of the settings. That copy picks up a new value only on the frame-start pulse supplied by the frame timing logic. This way a frame is never drawn with half-old and half-new settings.

A written value crosses into the display domain through a toggle request and acknowledge handshake. The bus side keeps the crossed value frozen until the acknowledge comes back, and a status flag then shows that the display side holds the latest write. If software writes again while a crossing is in flight, the newest value follows as soon as the current crossing ends. The two interrupt-enable fields are the exception to frame-boundary loading: the interrupt outputs use the bus-side copy, so these fields act as soon as they are written.

The status register carries an update-request and update-done pair, a start-of-frame flag, the synchronized voltage-pump ready input and the enable state. It drives two interrupt outputs. A display-domain output enables the low-resistance divider, and the buffer-enable control bit vetoes it.

Top module: `fsc_frame_ctrl`

## Requirements
- R1: After reset the status word reads 0x20, the frame-control and main-control words read 0, `act_cfg` is 0 and `irq_udd`, `irq_sof` and `lowres_en` are 0.
- R2: Reading the frame-control word (address 0x4) returns the last value written there, bits 24:0 only, at once, whatever configuration is active; bits 31:25 read 0.
- R3: `act_cfg` equals bits 22:0 of a frame-control value and changes only on a display clock edge where `frame_start` is 1. A frame start with nothing new captured leaves it unchanged.
- R4: The interrupt-enable fields (bit 23 start-of-frame enable, bit 24 update-done enable) affect the interrupt outputs in the bus cycle after the write, with no frame start needed.
- R5: Status bit 5 (sync) reads 0 from the first bus cycle after a frame-control write. It returns to 1 once the display domain has captured that value, before any frame start.
- R6: For writes issued back to back, only the last one becomes active at the next frame start once sync reads 1.
- R7: Status layout: bit 0 enable (main-control bit 0), bit 1 start-of-frame, bit 2 update request, bit 3 update done, bit 4 ready (`pump_ready` after synchronization), bit 5 sync. Bits 31:6 read 0.
- R8: The start-of-frame flag is set by each frame start while enabled. Writing 1 to bit 1 of the clear word (address 0xC) clears it. `irq_sof` is the flag ANDed with its enable bit.
- R9: Writing 1 to status bit 2 sets the update request. At the next frame start while enabled, the request clears and update done sets. While disabled, update done does not set.
- R10: Writing 1 to bit 3 of the clear word clears update done. A set in the same cycle as a clear wins.
- R11: `irq_udd` is 1 only when update done, its enable bit and main-control bit 0 are all 1.
- R12: `lowres_en` is 1 when enabled and active bit 22 (high drive) is 1 or active bits 21:19 (pulse-on) are non-zero. Main-control bit 1 (buffer enable) forces it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register-side clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write byte address (0x0 control, 0x4 frame control, 0x8 status, 0xC clear) |
| wdata | input | 32 | Write data |
| rd_addr | input | 4 | Read byte address |
| rdata | output | 32 | Read data, combinational from rd_addr |
| pump_ready | input | 1 | Voltage pump ready level, asynchronous |
| irq_sof | output | 1 | Start-of-frame interrupt |
| irq_udd | output | 1 | Update-done interrupt |
| disp_clk | input | 1 | Display-side clock |
| disp_rst | input | 1 | Synchronous active-high reset, display domain |
| frame_start | input | 1 | One-cycle frame-start pulse, display domain |
| act_cfg | output | 23 | Active frame-control fields (bits 22:0) |
| lowres_en | output | 1 | Low-resistance divider enable |

## Verification
The bench runs the bus and display clocks at unrelated periods and tries frame-control writes in several patterns. A single write followed by a frame start shows that loading waits for the frame boundary. A pair of writes issued back to back shows that only the newest value reaches the active copy. A write that touches only the interrupt enables shows that those fields bypass the frame boundary. A frame start with no preceding write shows the active copy is held. The update-done flag is exercised with the display enabled and disabled. It is also tested under a clear written on every bus cycle while the set arrives, which tells set-wins priority apart from clear-wins.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    localparam int unsigned BUS_W  = 32;
    localparam int unsigned ADDR_W = 4;

    // Word select taken from address bits 3:2
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_FCR  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_CLR  = 2'd3
    } reg_sel_e;

    // Bus-side frame-control word, bit 0 is prescale[0]
    typedef struct packed {
        logic       udd_ie;      // 24
        logic       sof_ie;      // 23
        logic       hi_drive;    // 22
        logic [2:0] pulse_on;    // 21:19
        logic [2:0] dead_time;   // 18:16
        logic [2:0] contrast;    // 15:13
        logic [2:0] blink_rate;  // 12:10
        logic [1:0] blink_mode;  // 9:8
        logic [3:0] divide;      // 7:4
        logic [3:0] prescale;    // 3:0
    } fcr_t;

    // Display-side active copy: everything except the interrupt enables
    typedef struct packed {
        logic       hi_drive;
        logic [2:0] pulse_on;
        logic [2:0] dead_time;
        logic [2:0] contrast;
        logic [2:0] blink_rate;
        logic [1:0] blink_mode;
        logic [3:0] divide;
        logic [3:0] prescale;
    } act_t;

    localparam int unsigned FCR_W = $bits(fcr_t);
    localparam int unsigned ACT_W = $bits(act_t);

    // Status word, packed so that en lands on bit 0 and sync on bit 5
    typedef struct packed {
        logic sync;
        logic ready;
        logic udd;
        logic udr;
        logic sof;
        logic en;
    } status_t;

    localparam int unsigned ST_W    = $bits(status_t);
    localparam int unsigned ST_SOF  = 1;
    localparam int unsigned ST_UDR  = 2;
    localparam int unsigned ST_UDD  = 3;
    localparam int unsigned CTL_EN  = 0;
    localparam int unsigned CTL_BUF = 1;

    function automatic fcr_t word_to_fcr(input logic [BUS_W-1:0] w);
        return fcr_t'(w[FCR_W-1:0]);
    endfunction

    function automatic act_t fcr_to_act(input fcr_t f);
        return act_t'(f[ACT_W-1:0]);
    endfunction

    function automatic reg_sel_e addr_to_sel(input logic [ADDR_W-1:0] a);
        return reg_sel_e'(a[3:2]);
    endfunction

endpackage

// File: rtl/fsc_bit_sync.sv
module fsc_bit_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/fsc_pulse_xing.sv
module fsc_pulse_xing #(
    parameter int unsigned STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst,
    output logic dst_pulse
);
    logic src_tgl_q;
    logic dst_tgl_s;
    logic dst_seen_q;

    always_ff @(posedge src_clk) begin
        if (src_rst)        src_tgl_q <= 1'b0;
        else if (src_pulse) src_tgl_q <= ~src_tgl_q;
    end

    fsc_bit_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_tgl_sync (
        .clk (dst_clk),
        .rst (dst_rst),
        .d   (src_tgl_q),
        .q   (dst_tgl_s)
    );

    always_ff @(posedge dst_clk) begin
        if (dst_rst) dst_seen_q <= 1'b0;
        else         dst_seen_q <= dst_tgl_s;
    end

    assign dst_pulse = dst_tgl_s ^ dst_seen_q;
endmodule

// File: rtl/fsc_shadow_xfer.sv
module fsc_shadow_xfer
    import fsc_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic bus_clk,
    input  logic bus_rst,
    input  logic wr_fcr,
    input  fcr_t wr_val,
    output fcr_t bus_fcr,
    output logic sync_flag,
    input  logic disp_clk,
    input  logic disp_rst,
    input  logic frame_start,
    output act_t act_cfg
);
    // ---------------- bus domain ----------------
    fcr_t fcr_q;
    fcr_t hold_q;
    logic req_q;
    logic dirty_q;
    logic sync_q;
    logic ack_s;
    logic busy;
    logic launch;

    assign busy   = req_q ^ ack_s;
    assign launch = dirty_q && !busy && !wr_fcr;

    always_ff @(posedge bus_clk) begin
        if (bus_rst) begin
            fcr_q   <= '0;
            hold_q  <= '0;
            req_q   <= 1'b0;
            dirty_q <= 1'b0;
            sync_q  <= 1'b1;
        end else begin
            if (wr_fcr) begin
                fcr_q   <= wr_val;
                dirty_q <= 1'b1;
                sync_q  <= 1'b0;
            end else if (launch) begin
                hold_q  <= fcr_q;
                req_q   <= ~req_q;
                dirty_q <= 1'b0;
            end else if (!busy && !dirty_q) begin
                sync_q  <= 1'b1;
            end
        end
    end

    assign bus_fcr   = fcr_q;
    assign sync_flag = sync_q;

    // ---------------- display domain ----------------
    logic req_s;
    logic ack_q;
    logic stage_vld_q;
    fcr_t stage_q;
    act_t act_q;
    logic capture;

    fsc_bit_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_req_sync (
        .clk (disp_clk),
        .rst (disp_rst),
        .d   (req_q),
        .q   (req_s)
    );

    fsc_bit_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_ack_sync (
        .clk (bus_clk),
        .rst (bus_rst),
        .d   (ack_q),
        .q   (ack_s)
    );

    assign capture = req_s ^ ack_q;

    always_ff @(posedge disp_clk) begin
        if (disp_rst) begin
            ack_q       <= 1'b0;
            stage_vld_q <= 1'b0;
            stage_q     <= '0;
            act_q       <= '0;
        end else begin
            if (capture) begin
                stage_q <= hold_q;
                ack_q   <= req_s;
            end
            if (capture)          stage_vld_q <= 1'b1;
            else if (frame_start) stage_vld_q <= 1'b0;
            if (frame_start && stage_vld_q) act_q <= fcr_to_act(stage_q);
        end
    end

    assign act_cfg = act_q;

    // R5/R6: the crossed value stays frozen while a request is outstanding
    p_hold_frozen_r6: assert property (@(posedge bus_clk) disable iff (bus_rst)
        busy |=> $stable(hold_q));

    // R5: a write always knocks the sync flag down on the next cycle
    p_sync_drop_r5: assert property (@(posedge bus_clk) disable iff (bus_rst)
        wr_fcr |=> !sync_flag);

    // R3: active copy moves only after a frame-start edge
    p_frame_only_r3: assert property (@(posedge disp_clk) disable iff (disp_rst)
        !frame_start |=> $stable(act_q));
endmodule

// File: rtl/fsc_status.sv
module fsc_status
    import fsc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ctrl_en,
    input  logic    ready_s,
    input  logic    sync_flag,
    input  logic    sof_evt,
    input  logic    udd_evt,
    input  logic    udr_req,
    input  logic    clr_sof,
    input  logic    clr_udd,
    output status_t st
);
    logic sof_q;
    logic udr_q;
    logic udd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sof_q <= 1'b0;
            udr_q <= 1'b0;
            udd_q <= 1'b0;
        end else begin
            if (sof_evt)      sof_q <= 1'b1;
            else if (clr_sof) sof_q <= 1'b0;

            if (udd_evt)      udd_q <= 1'b1;
            else if (clr_udd) udd_q <= 1'b0;

            if (udr_req)      udr_q <= 1'b1;
            else if (udd_evt) udr_q <= 1'b0;
        end
    end

    always_comb begin
        st       = '0;
        st.en    = ctrl_en;
        st.sof   = sof_q;
        st.udr   = udr_q;
        st.udd   = udd_q;
        st.ready = ready_s;
        st.sync  = sync_flag;
    end

    // R10: set beats clear in the same cycle
    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        udd_evt |=> st.udd);

    // R8: a clear with no coinciding event empties the flag
    p_sof_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (clr_sof && !sof_evt) |=> !st.sof);
endmodule

// File: rtl/fsc_frame_ctrl.sv
module fsc_frame_ctrl
    import fsc_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic              bus_clk,
    input  logic              bus_rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BUS_W-1:0]  rdata,
    input  logic              pump_ready,
    output logic              irq_sof,
    output logic              irq_udd,
    input  logic              disp_clk,
    input  logic              disp_rst,
    input  logic              frame_start,
    output logic [ACT_W-1:0]  act_cfg,
    output logic              lowres_en
);
    reg_sel_e wsel;
    reg_sel_e rsel;
    logic     ctrl_en_q;
    logic     ctrl_buf_q;
    logic     wr_fcr;
    logic     udr_req;
    logic     clr_sof;
    logic     clr_udd;
    fcr_t     bus_fcr;
    act_t     act;
    logic     sync_flag;
    logic     ready_s;
    logic     sof_evt;
    logic     udd_evt;
    status_t  st;

    assign wsel    = addr_to_sel(wr_addr);
    assign rsel    = addr_to_sel(rd_addr);
    assign wr_fcr  = wr_en && (wsel == SEL_FCR);
    assign udr_req = wr_en && (wsel == SEL_STAT) && wdata[ST_UDR];
    assign clr_sof = wr_en && (wsel == SEL_CLR) && wdata[ST_SOF];
    assign clr_udd = wr_en && (wsel == SEL_CLR) && wdata[ST_UDD];

    always_ff @(posedge bus_clk) begin
        if (bus_rst) begin
            ctrl_en_q  <= 1'b0;
            ctrl_buf_q <= 1'b0;
        end else if (wr_en && wsel == SEL_CTRL) begin
            ctrl_en_q  <= wdata[CTL_EN];
            ctrl_buf_q <= wdata[CTL_BUF];
        end
    end

    fsc_shadow_xfer #(.STAGES(STAGES)) u_xfer (
        .bus_clk     (bus_clk),
        .bus_rst     (bus_rst),
        .wr_fcr      (wr_fcr),
        .wr_val      (word_to_fcr(wdata)),
        .bus_fcr     (bus_fcr),
        .sync_flag   (sync_flag),
        .disp_clk    (disp_clk),
        .disp_rst    (disp_rst),
        .frame_start (frame_start),
        .act_cfg     (act)
    );

    fsc_bit_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_ready_sync (
        .clk (bus_clk),
        .rst (bus_rst),
        .d   (pump_ready),
        .q   (ready_s)
    );

    // ---------------- display-side control ----------------
    logic en_s;
    logic buf_s;
    logic udr_arrive;
    logic disp_udr_q;
    logic udd_done;
    logic sof_disp;

    fsc_bit_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_en_sync (
        .clk (disp_clk),
        .rst (disp_rst),
        .d   (ctrl_en_q),
        .q   (en_s)
    );

    fsc_bit_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_buf_sync (
        .clk (disp_clk),
        .rst (disp_rst),
        .d   (ctrl_buf_q),
        .q   (buf_s)
    );

    fsc_pulse_xing #(.STAGES(STAGES)) u_udr_xing (
        .src_clk   (bus_clk),
        .src_rst   (bus_rst),
        .src_pulse (udr_req),
        .dst_clk   (disp_clk),
        .dst_rst   (disp_rst),
        .dst_pulse (udr_arrive)
    );

    assign udd_done = frame_start && en_s && disp_udr_q;
    assign sof_disp = frame_start && en_s;

    always_ff @(posedge disp_clk) begin
        if (disp_rst)        disp_udr_q <= 1'b0;
        else if (udr_arrive) disp_udr_q <= 1'b1;
        else if (udd_done)   disp_udr_q <= 1'b0;
    end

    fsc_pulse_xing #(.STAGES(STAGES)) u_udd_xing (
        .src_clk   (disp_clk),
        .src_rst   (disp_rst),
        .src_pulse (udd_done),
        .dst_clk   (bus_clk),
        .dst_rst   (bus_rst),
        .dst_pulse (udd_evt)
    );

    fsc_pulse_xing #(.STAGES(STAGES)) u_sof_xing (
        .src_clk   (disp_clk),
        .src_rst   (disp_rst),
        .src_pulse (sof_disp),
        .dst_clk   (bus_clk),
        .dst_rst   (bus_rst),
        .dst_pulse (sof_evt)
    );

    assign lowres_en = en_s && !buf_s && (act.hi_drive || (act.pulse_on != '0));
    assign act_cfg   = act;

    // ---------------- status and interrupts ----------------
    fsc_status u_status (
        .clk       (bus_clk),
        .rst       (bus_rst),
        .ctrl_en   (ctrl_en_q),
        .ready_s   (ready_s),
        .sync_flag (sync_flag),
        .sof_evt   (sof_evt),
        .udd_evt   (udd_evt),
        .udr_req   (udr_req),
        .clr_sof   (clr_sof),
        .clr_udd   (clr_udd),
        .st        (st)
    );

    assign irq_sof = st.sof && bus_fcr.sof_ie;
    assign irq_udd = st.udd && bus_fcr.udd_ie && ctrl_en_q;

    always_comb begin
        rdata = '0;
        unique case (rsel)
            SEL_CTRL: begin
                rdata[CTL_EN]  = ctrl_en_q;
                rdata[CTL_BUF] = ctrl_buf_q;
            end
            SEL_FCR:  rdata[FCR_W-1:0] = bus_fcr;
            SEL_STAT: rdata[ST_W-1:0]  = st;
            SEL_CLR:  rdata = '0;
        endcase
    end

    // R12: buffer enable vetoes the divider once it has crossed over
    p_lowres_veto_r12: assert property (@(posedge disp_clk) disable iff (disp_rst)
        buf_s |-> !lowres_en);

    // R9: display side only retires a request while enabled
    p_udd_needs_en_r9: assert property (@(posedge disp_clk) disable iff (disp_rst)
        udd_done |-> en_s);
endmodule

// File: tb/fsc_frame_ctrl_test.sv
`timescale 1ns/1ps
module fsc_frame_ctrl_test;
    logic        bus_clk = 1'b0;
    logic        disp_clk = 1'b0;
    logic        bus_rst = 1'b1;
    logic        disp_rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rdata;
    logic        pump_ready = 1'b0;
    logic        irq_sof;
    logic        irq_udd;
    logic        frame_start = 1'b0;
    logic [22:0] act_cfg;
    logic        lowres_en;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4    bus_clk  = ~bus_clk;   // 125 MHz
    always #18.5 disp_clk = ~disp_clk;

    fsc_frame_ctrl uut (
        .bus_clk(bus_clk), .bus_rst(bus_rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wdata(wdata), .rd_addr(rd_addr), .rdata(rdata), .pump_ready(pump_ready),
        .irq_sof(irq_sof), .irq_udd(irq_udd), .disp_clk(disp_clk), .disp_rst(disp_rst),
        .frame_start(frame_start), .act_cfg(act_cfg), .lowres_en(lowres_en)
    );

    localparam logic [3:0] A_CTRL = 4'h0, A_FCR = 4'h4, A_STAT = 4'h8, A_CLR = 4'hC;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge bus_clk); #1;
        wr_en = 1'b1; wr_addr = a; wdata = d;
        @(posedge bus_clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge bus_clk);
        rd_addr = a;
        #1 d = rdata;
    endtask

    task automatic frame();
        repeat (4) @(posedge disp_clk);
        #1 frame_start = 1'b1;
        @(posedge disp_clk); #1 frame_start = 1'b0;
        repeat (2) @(posedge disp_clk);
        #1;
    endtask

    task automatic wait_sync();
        logic [31:0] s;
        for (int i = 0; i < 200; i++) begin
            bus_rd(A_STAT, s);
            if (s[5]) break;
        end
    endtask

    task automatic settle_bus();
        repeat (12) @(posedge bus_clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bus_rd(A_STAT, v); chk("R1 status reset", v, 32'h20);
        bus_rd(A_FCR, v);  chk("R1 fcr reset", v, 0);
        bus_rd(A_CTRL, v); chk("R1 ctrl reset", v, 0);
        chk("R1 act reset", {9'd0, act_cfg}, 0);
        chk("R1 irq/lowres reset", {29'd0, irq_udd, irq_sof, lowres_en}, 0);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        bus_wr(A_FCR, 32'hFFFF_FFFF);
        bus_rd(A_FCR, v); chk("R2 readback masked", v, 32'h01FF_FFFF);
        chk("R3 act untouched by write", {9'd0, act_cfg}, 0);
        bus_wr(A_FCR, 32'h0012_3456);
        bus_rd(A_FCR, v); chk("R2 readback", v, 32'h0012_3456);
    endtask

    task automatic t_sync_and_frame();
        logic [31:0] v;
        bus_wr(A_FCR, 32'h0003_0C21);
        bus_rd(A_STAT, v); chk("R5 sync cleared by write", {31'd0, v[5]}, 0);
        wait_sync();
        bus_rd(A_STAT, v); chk("R5 sync set after capture", {31'd0, v[5]}, 1);
        chk("R3 act waits for frame", {9'd0, act_cfg}, 0);
        frame();
        chk("R3 act loaded at frame", {9'd0, act_cfg}, 32'h0003_0C21);
        frame();
        chk("R3 act held without write", {9'd0, act_cfg}, 32'h0003_0C21);
    endtask

    task automatic t_back_to_back();
        logic [31:0] v;
        bus_wr(A_FCR, 32'h0012_3456);
        bus_wr(A_FCR, 32'h0065_4321);
        bus_rd(A_STAT, v); chk("R5 sync low while pending", {31'd0, v[5]}, 0);
        wait_sync();
        frame();
        chk("R6 last write wins", {9'd0, act_cfg}, 32'h0065_4321);
    endtask

    task automatic t_sof_and_ie();
        logic [31:0] v;
        bus_wr(A_CTRL, 32'h1);
        bus_wr(A_CLR, 32'h2);
        frame(); settle_bus();
        bus_rd(A_STAT, v); chk("R8 sof flag set", {31'd0, v[1]}, 1);
        chk("R7 status bit0 enable", {31'd0, v[0]}, 1);
        chk("R8 irq_sof gated by enable", {31'd0, irq_sof}, 0);
        bus_wr(A_FCR, 32'h0065_4321 | 32'h0080_0000);
        chk("R4 sof enable acts at once", {31'd0, irq_sof}, 1);
        chk("R4 act unchanged", {9'd0, act_cfg}, 32'h0065_4321);
        bus_wr(A_CLR, 32'h2);
        bus_rd(A_STAT, v); chk("R8 sof cleared", {31'd0, v[1]}, 0);
        chk("R8 irq_sof drops", {31'd0, irq_sof}, 0);
    endtask

    task automatic t_update();
        logic [31:0] v;
        bus_wr(A_FCR, 32'h0065_4321 | 32'h0100_0000);
        wait_sync();
        bus_wr(A_STAT, 32'h4);
        bus_rd(A_STAT, v); chk("R9 request bit set", {30'd0, v[3:2]}, 32'h1);
        settle_bus();
        bus_rd(A_STAT, v); chk("R9 no done before frame", {31'd0, v[3]}, 0);
        frame(); settle_bus();
        bus_rd(A_STAT, v); chk("R9 done and request cleared", {30'd0, v[3:2]}, 32'h2);
        chk("R11 irq_udd asserted", {31'd0, irq_udd}, 1);
        bus_wr(A_CTRL, 32'h0);
        chk("R11 irq_udd off while disabled", {31'd0, irq_udd}, 0);
        bus_wr(A_CTRL, 32'h1);
        chk("R11 irq_udd back", {31'd0, irq_udd}, 1);
        bus_wr(A_FCR, 32'h0065_4321);
        chk("R11 irq_udd off with enable bit low", {31'd0, irq_udd}, 0);
        bus_wr(A_CLR, 32'h8);
        bus_rd(A_STAT, v); chk("R10 done cleared", {31'd0, v[3]}, 0);
        wait_sync();
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        bus_wr(A_CTRL, 32'h0);
        bus_wr(A_STAT, 32'h4);
        frame(); settle_bus();
        bus_rd(A_STAT, v); chk("R9 no done while disabled", {31'd0, v[3]}, 0);
        bus_wr(A_CTRL, 32'h1);
        frame(); settle_bus();
        bus_rd(A_STAT, v); chk("R9 done after enabling", {31'd0, v[3]}, 1);
        bus_wr(A_CLR, 32'h8);
    endtask

    task automatic t_set_wins();
        int seen = 0;
        logic [31:0] v;
        bus_wr(A_STAT, 32'h4);
        @(posedge bus_clk); #1;
        rd_addr = A_STAT;
        wr_en = 1'b1; wr_addr = A_CLR; wdata = 32'h8;
        fork
            frame();
            for (int i = 0; i < 90; i++) begin
                @(negedge bus_clk);
                if (rdata[3]) seen++;
            end
        join
        @(posedge bus_clk); #1 wr_en = 1'b0;
        chk("R10 set wins over clear", seen, 1);
        bus_rd(A_STAT, v); chk("R10 cleared afterwards", {31'd0, v[3]}, 0);
    endtask

    task automatic t_lowres();
        bus_wr(A_FCR, 32'h0040_0000);
        wait_sync(); frame();
        chk("R12 high drive enables divider", {31'd0, lowres_en}, 1);
        bus_wr(A_CTRL, 32'h3);
        repeat (4) @(posedge disp_clk); #1;
        chk("R12 buffer enable forces off", {31'd0, lowres_en}, 0);
        bus_wr(A_CTRL, 32'h1);
        bus_wr(A_FCR, 32'h0010_0000);
        wait_sync(); frame();
        chk("R12 pulse-on enables divider", {31'd0, lowres_en}, 1);
        bus_wr(A_FCR, 32'h0000_0000);
        wait_sync(); frame();
        chk("R12 neither drive nor pulse-on", {31'd0, lowres_en}, 0);
    endtask

    task automatic t_ready();
        logic [31:0] v;
        pump_ready = 1'b1;
        repeat (4) @(posedge bus_clk);
        bus_rd(A_STAT, v); chk("R7 ready and enable bits", v, 32'h31);
    endtask

    initial begin
        repeat (5) @(posedge disp_clk);
        #1 bus_rst = 1'b0; disp_rst = 1'b0;
        repeat (2) @(posedge bus_clk);
        t_reset();
        t_readback();
        wait_sync();
        t_sync_and_frame();
        t_back_to_back();
        t_sof_and_ie();
        t_update();
        t_disabled();
        t_set_wins();
        t_lowres();
        bus_wr(A_CLR, 32'h2);
        t_ready();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule